// File: doc/BRIEF.md
# Multi-Criteria Packet Queue Classifier

This block chooses one of four egress queues for each Ethernet frame. An upstream parser supplies a descriptor for each frame. The descriptor carries the VLAN identifier, the 3-bit user priority code, the 6-bit IPv4 DSCP, and two presence flags. The block checks three small lookup tables: one indexed by VLAN, one by priority code and one by DSCP. It consults them in a precedence order that software sets. It returns the queue from the first table whose entry is valid. A field that the frame does not carry counts as a miss. When every lookup misses, the frame goes to a programmable default queue.

Software fills the tables and the default queue through a single write port. It sets the precedence by giving each criterion a level from 1 to 3. Level 1 is consulted first. Each level may be held by only one criterion. A precedence write that breaks this rule is rejected, and the order already in force stays active.

The core is a three-state controller:
- **S_IDLE**: waiting.
- **S_READ**: the table reads are in flight.
- **S_EMIT**: the result is presented.

Its transitions are:
- S_IDLE → S_READ when a descriptor strobe arrives.
- S_READ → S_EMIT always.
- S_EMIT → S_READ when a new strobe arrives in S_EMIT.
- S_EMIT → S_IDLE otherwise.

Top module: `qcls_top`

## Requirements
- R1: For a descriptor strobe `desc_valid` sampled at a clock edge, `q_valid` is high for exactly one cycle after the second following edge, with `q_index` in the range 0 to 3.
- R2: A configuration write stores an entry made of `cfg_data[2]` (valid) and `cfg_data[1:0]` (queue). The target depends on `cfg_sel`: 0 selects the VLAN table at `cfg_addr[5:0]`, 1 selects the priority-code table at `cfg_addr[2:0]`, and 2 selects the DSCP table at `cfg_addr[5:0]`. With `cfg_sel` = 3, the write sets the default queue from `cfg_data[1:0]`.
- R3: The criterion whose level is 1 is consulted first, then level 2, then level 3. After reset the levels are VLAN = 1, priority code = 2, DSCP = 3.
- R4: If the entry read for a criterion is invalid, the result comes from the next criterion in precedence order that has a valid entry.
- R5: With `desc_has_vlan` = 0, the VLAN and priority-code lookups count as invalid. With `desc_has_ipv4` = 0, the DSCP lookup counts as invalid.
- R6: If all three lookups are invalid, `q_index` equals the default queue, which is 0 after reset.
- R7: A precedence write is rejected in two cases: a level is 0, or two criteria share a level. After a rejected write, `prio_err` is 1 from the next cycle and the previous order stays in force. An accepted write clears `prio_err`.
- R8: A `desc_valid` that arrives in the cycle directly after an accepted strobe is ignored. It produces no result.
- R9: After reset every table entry is invalid and `prio_err` is 0.
- R10: The VLAN table is indexed by the low 6 bits of the VLAN ID, so IDs that differ only above bit 5 share an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor strobe |
| desc_vid | input | 12 | VLAN identifier |
| desc_pcp | input | 3 | User priority code |
| desc_dscp | input | 6 | IPv4 DSCP value |
| desc_has_vlan | input | 1 | Frame carries a VLAN tag |
| desc_has_ipv4 | input | 1 | Frame is IPv4 |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: VLAN, priority code, DSCP, default |
| cfg_addr | input | 6 | Table index |
| cfg_data | input | 3 | {valid, queue} |
| prio_wr | input | 1 | Precedence write strobe |
| prio_vlan | input | 2 | Level for VLAN criterion |
| prio_pcp | input | 2 | Level for priority-code criterion |
| prio_dscp | input | 2 | Level for DSCP criterion |
| q_valid | output | 1 | Result strobe |
| q_index | output | 2 | Selected queue |
| prio_err | output | 1 | Last precedence write was rejected |

## Verification
The bench covers several corner cases, and each one catches a specific kind of fault:
- **Fallback through all three levels.** A misses-all vector must land on the programmed default queue. A design with a broken fallback chain would return the wrong level's queue or a stale table value.
- **Presence flags.** Untagged and non-IPv4 frames whose fields would otherwise hit are checked. A design that ignored the flags would route them by table contents.
- **Reordered and rejected precedence.** The precedence is reordered, then a duplicate-level write and a zero-level write are applied. A design that accepted the bad writes would change the routing and leave `prio_err` low.
- **VLAN aliasing and mid-lookup strobes.** A VLAN ID above 63 must alias to its low-bit entry. A second strobe in the read cycle must produce no extra result; a design that latched it would emit two pulses.

// File: rtl/qcls_pkg.sv
package qcls_pkg;
    localparam int NUM_QUEUES = 4;
    localparam int QW         = $clog2(NUM_QUEUES);
    localparam int NUM_CRIT   = 3;
    localparam int LVL_W      = 2;
    localparam int TAB_AW     = 6;
    localparam int PCP_W      = 3;
    localparam int CR_VLAN    = 0;
    localparam int CR_PCP     = 1;
    localparam int CR_DSCP    = 2;
    localparam logic [1:0] SEL_DFLT = 2'd3;

    typedef struct packed {
        logic          vld;
        logic [QW-1:0] q;
    } qent_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_READ = 2'd1,
        S_EMIT = 2'd2
    } cls_state_t;
endpackage

// File: rtl/qcls_table.sv
module qcls_table
    import qcls_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  qent_t         wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output qent_t         rd_data
);
    localparam int DEPTH = 1 << AW;

    qent_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/qcls_rank.sv
module qcls_rank
    import qcls_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [NUM_CRIT-1:0][LVL_W-1:0] lvl_in,
    output logic [NUM_CRIT-1:0][LVL_W-1:0] rank,
    output logic                           err
);
    logic legal;

    always_comb begin
        legal = 1'b1;
        for (int a = 0; a < NUM_CRIT; a++) begin
            if (lvl_in[a] == '0) legal = 1'b0;
            for (int b = a + 1; b < NUM_CRIT; b++)
                if (lvl_in[a] == lvl_in[b]) legal = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CRIT; c++) rank[c] <= LVL_W'(c + 1);
            err <= 1'b0;
        end else if (wr_en) begin
            if (legal) rank <= lvl_in;
            err <= !legal;
        end
    end
endmodule

// File: rtl/qcls_top.sv
module qcls_top
    import qcls_pkg::*;
#(
    parameter int VID_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_valid,
    input  logic [VID_W-1:0] desc_vid,
    input  logic [2:0]       desc_pcp,
    input  logic [5:0]       desc_dscp,
    input  logic             desc_has_vlan,
    input  logic             desc_has_ipv4,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_sel,
    input  logic [5:0]       cfg_addr,
    input  logic [2:0]       cfg_data,
    input  logic             prio_wr,
    input  logic [1:0]       prio_vlan,
    input  logic [1:0]       prio_pcp,
    input  logic [1:0]       prio_dscp,
    output logic             q_valid,
    output logic [1:0]       q_index,
    output logic             prio_err
);
    cls_state_t state, state_nx;
    logic accept;

    logic [NUM_CRIT-1:0][LVL_W-1:0]  rank;
    logic [NUM_CRIT-1:0][TAB_AW-1:0] rd_addr;
    logic [NUM_CRIT-1:0]             present_q;
    logic [NUM_CRIT-1:0]             hit;
    qent_t                           ent [NUM_CRIT];
    logic [QW-1:0]                   dflt_q;
    logic [QW-1:0]                   sel_q;
    logic [QW-1:0]                   res_q;

    assign accept = desc_valid && (state != S_READ);

    assign rd_addr[CR_VLAN] = desc_vid[TAB_AW-1:0];
    assign rd_addr[CR_PCP]  = TAB_AW'(desc_pcp);
    assign rd_addr[CR_DSCP] = desc_dscp;

    generate
        for (genvar c = 0; c < NUM_CRIT; c++) begin : g_tab
            localparam int AW_C = (c == CR_PCP) ? PCP_W : TAB_AW;
            qcls_table #(.AW(AW_C)) u_tab (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (cfg_wr && (cfg_sel == 2'(c))),
                .wr_addr (cfg_addr[AW_C-1:0]),
                .wr_data (qent_t'(cfg_data)),
                .rd_en   (accept),
                .rd_addr (rd_addr[c][AW_C-1:0]),
                .rd_data (ent[c])
            );
            assign hit[c] = ent[c].vld && present_q[c];
        end
    endgenerate

    qcls_rank u_rank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (prio_wr),
        .lvl_in ({prio_dscp, prio_pcp, prio_vlan}),
        .rank   (rank),
        .err    (prio_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                            dflt_q <= '0;
        else if (cfg_wr && cfg_sel == SEL_DFLT) dflt_q <= cfg_data[QW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present_q <= '0;
        end else if (accept) begin
            present_q[CR_VLAN] <= desc_has_vlan;
            present_q[CR_PCP]  <= desc_has_vlan;
            present_q[CR_DSCP] <= desc_has_ipv4;
        end
    end

    // Walk levels from lowest to highest precedence; the last hit wins.
    always_comb begin
        sel_q = dflt_q;
        for (int lvl = NUM_CRIT; lvl >= 1; lvl--)
            for (int c = 0; c < NUM_CRIT; c++)
                if (rank[c] == LVL_W'(lvl) && hit[c]) sel_q = ent[c].q;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (desc_valid) state_nx = S_READ;
            S_READ:  state_nx = S_EMIT;
            S_EMIT:  state_nx = desc_valid ? S_READ : S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)               res_q <= '0;
        else if (state == S_READ) res_q <= sel_q;
    end

    always_comb begin
        q_valid = (state == S_EMIT);
        q_index = res_q;
    end
endmodule

// File: rtl/qcls_checker.sv
module qcls_checker
    import qcls_pkg::*;
(
    input logic                           clk,
    input logic                           rst_n,
    input logic                           desc_valid,
    input logic                           desc_has_vlan,
    input logic                           desc_has_ipv4,
    input logic                           prio_wr,
    input logic [1:0]                     prio_vlan,
    input logic [1:0]                     prio_pcp,
    input logic [1:0]                     prio_dscp,
    input logic                           q_valid,
    input logic [1:0]                     q_index,
    input logic                           prio_err,
    input logic [NUM_CRIT-1:0][LVL_W-1:0] rank,
    input logic [QW-1:0]                  dflt_q
);
    logic bad_wr;
    assign bad_wr = prio_wr && (prio_vlan == 2'd0 || prio_pcp == 2'd0 || prio_dscp == 2'd0 ||
                                prio_vlan == prio_pcp || prio_vlan == prio_dscp ||
                                prio_pcp == prio_dscp);

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |-> $past(desc_valid, 2));

    assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> !q_valid);

    assert_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |-> !$isunknown(q_index));

    assert_rank_distinct_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rank[0] != rank[1]) && (rank[0] != rank[2]) && (rank[1] != rank[2]) &&
        (rank[0] != 2'd0) && (rank[1] != 2'd0) && (rank[2] != 2'd0));

    assert_reject_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> prio_err && (rank == $past(rank)));

    assert_absent_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && !$past(desc_has_vlan, 2) && !$past(desc_has_ipv4, 2)) |-> q_index == dflt_q);
endmodule

bind qcls_top qcls_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .desc_valid    (desc_valid),
    .desc_has_vlan (desc_has_vlan),
    .desc_has_ipv4 (desc_has_ipv4),
    .prio_wr       (prio_wr),
    .prio_vlan     (prio_vlan),
    .prio_pcp      (prio_pcp),
    .prio_dscp     (prio_dscp),
    .q_valid       (q_valid),
    .q_index       (q_index),
    .prio_err      (prio_err),
    .rank          (rank),
    .dflt_q        (dflt_q)
);

// File: tb/qcls_top_test.sv
`timescale 1ns/1ps
module qcls_top_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        desc_valid, desc_has_vlan, desc_has_ipv4;
    logic [11:0] desc_vid;
    logic [2:0]  desc_pcp;
    logic [5:0]  desc_dscp;
    logic        cfg_wr, prio_wr;
    logic [1:0]  cfg_sel, prio_vlan, prio_pcp, prio_dscp;
    logic [5:0]  cfg_addr;
    logic [2:0]  cfg_data;
    logic        q_valid, prio_err;
    logic [1:0]  q_index;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    qcls_top uut (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_vid(desc_vid),
        .desc_pcp(desc_pcp), .desc_dscp(desc_dscp), .desc_has_vlan(desc_has_vlan),
        .desc_has_ipv4(desc_has_ipv4), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .prio_wr(prio_wr),
        .prio_vlan(prio_vlan), .prio_pcp(prio_pcp), .prio_dscp(prio_dscp),
        .q_valid(q_valid), .q_index(q_index), .prio_err(prio_err)
    );

    typedef struct packed {
        logic [11:0] vid;
        logic [2:0]  pcp;
        logic [5:0]  dscp;
        logic        hv;
        logic        hi;
        logic [1:0]  exp;
    } vec_t;

    // Tables: VLAN 5->1, 7->2; PCP 5->3, 2->1; DSCP 46->0, 10->1; default 2.
    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{12'd5,  3'd5, 6'd46, 1'b1, 1'b1, 2'd1},  // R3 VLAN wins
        '{12'd9,  3'd5, 6'd46, 1'b1, 1'b1, 2'd3},  // R4 falls to PCP
        '{12'd9,  3'd1, 6'd46, 1'b1, 1'b1, 2'd0},  // R4 falls to DSCP
        '{12'd9,  3'd1, 6'd0,  1'b1, 1'b1, 2'd2},  // R6 all miss
        '{12'd5,  3'd5, 6'd46, 1'b0, 1'b1, 2'd0},  // R5 untagged
        '{12'd9,  3'd1, 6'd46, 1'b1, 1'b0, 2'd2},  // R5 non-IPv4
        '{12'd5,  3'd5, 6'd46, 1'b0, 1'b0, 2'd2},  // R6 nothing present
        '{12'd69, 3'd0, 6'd0,  1'b1, 1'b0, 2'd1},  // R10 alias of 5
        '{12'd7,  3'd2, 6'd10, 1'b1, 1'b1, 2'd2}   // R2 VLAN 7 entry
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [5:0] addr, input logic [2:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_addr = addr; cfg_data = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_prio(input logic [1:0] v, input logic [1:0] p, input logic [1:0] d);
        @(negedge clk);
        prio_wr = 1'b1; prio_vlan = v; prio_pcp = p; prio_dscp = d;
        @(negedge clk);
        prio_wr = 1'b0;
    endtask

    task automatic drive(input logic [11:0] vid, input logic [2:0] pcp, input logic [5:0] dscp,
                         input logic hv, input logic hi);
        desc_valid = 1'b1; desc_vid = vid; desc_pcp = pcp; desc_dscp = dscp;
        desc_has_vlan = hv; desc_has_ipv4 = hi;
    endtask

    task automatic classify(input string req, input logic [11:0] vid, input logic [2:0] pcp,
                            input logic [5:0] dscp, input logic hv, input logic hi,
                            input logic [1:0] exp);
        @(negedge clk);
        drive(vid, pcp, dscp, hv, hi);
        @(negedge clk);
        desc_valid = 1'b0;
        @(negedge clk);
        check({req, " q_valid"}, {3'b0, q_valid}, 4'd1);
        check({req, " q_index"}, {2'b0, q_index}, {2'b0, exp});
        @(negedge clk);
        check({req, " pulse end"}, {3'b0, q_valid}, 4'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; desc_valid = 1'b0; desc_vid = '0; desc_pcp = '0; desc_dscp = '0;
        desc_has_vlan = 1'b0; desc_has_ipv4 = 1'b0; cfg_wr = 1'b0; cfg_sel = '0;
        cfg_addr = '0; cfg_data = '0; prio_wr = 1'b0; prio_vlan = '0; prio_pcp = '0;
        prio_dscp = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state, empty tables route to reset default 0
        check("R9 prio_err", {3'b0, prio_err}, 4'd0);
        check("R9 q_valid", {3'b0, q_valid}, 4'd0);
        classify("R9", 12'd5, 3'd5, 6'd46, 1'b1, 1'b1, 2'd0);

        cfg(2'd0, 6'd5,  3'b101);
        cfg(2'd0, 6'd7,  3'b110);
        cfg(2'd1, 6'd5,  3'b111);
        cfg(2'd1, 6'd2,  3'b101);
        cfg(2'd2, 6'd46, 3'b100);
        cfg(2'd2, 6'd10, 3'b101);
        cfg(2'd3, 6'd0,  3'b010);

        for (int i = 0; i < NV; i++)
            classify($sformatf("vec%0d R1", i), VEC[i].vid, VEC[i].pcp, VEC[i].dscp,
                     VEC[i].hv, VEC[i].hi, VEC[i].exp);

        // R3: reorder to DSCP=1, PCP=2, VLAN=3
        set_prio(2'd3, 2'd2, 2'd1);
        check("R7 prio_err clear", {3'b0, prio_err}, 4'd0);
        classify("R3 dscp first", 12'd7, 3'd2, 6'd10, 1'b1, 1'b1, 2'd1);
        classify("R3 pcp second", 12'd7, 3'd5, 6'd0,  1'b1, 1'b1, 2'd3);
        classify("R3 vlan third", 12'd7, 3'd1, 6'd0,  1'b1, 1'b1, 2'd2);

        // R7: duplicate level rejected, order kept
        set_prio(2'd1, 2'd1, 2'd2);
        check("R7 prio_err dup", {3'b0, prio_err}, 4'd1);
        classify("R7 order kept", 12'd5, 3'd5, 6'd10, 1'b1, 1'b1, 2'd1);
        set_prio(2'd0, 2'd2, 2'd3);
        check("R7 prio_err zero", {3'b0, prio_err}, 4'd1);
        classify("R7 order kept zero", 12'd5, 3'd5, 6'd0, 1'b1, 1'b1, 2'd3);
        set_prio(2'd1, 2'd2, 2'd3);
        check("R7 prio_err cleared", {3'b0, prio_err}, 4'd0);

        // R2: overwrite VLAN 5 as invalid, falls to PCP
        cfg(2'd0, 6'd5, 3'b001);
        classify("R2 overwrite", 12'd5, 3'd5, 6'd46, 1'b1, 1'b1, 2'd3);

        // R8: second strobe in read cycle is ignored
        @(negedge clk);
        drive(12'd7, 3'd0, 6'd0, 1'b1, 1'b0);
        @(negedge clk);
        drive(12'd9, 3'd0, 6'd0, 1'b0, 1'b0);
        @(negedge clk);
        desc_valid = 1'b0;
        check("R8 first q_valid", {3'b0, q_valid}, 4'd1);
        check("R8 first q_index", {2'b0, q_index}, 4'd2);
        @(negedge clk);
        check("R8 no second pulse", {3'b0, q_valid}, 4'd0);
        @(negedge clk);
        check("R8 still quiet", {3'b0, q_valid}, 4'd0);

        // R1: back-to-back accepted strobes two cycles apart
        @(negedge clk);
        drive(12'd7, 3'd0, 6'd0, 1'b1, 1'b0);
        @(negedge clk);
        desc_valid = 1'b0;
        @(negedge clk);
        drive(12'd0, 3'd5, 6'd0, 1'b1, 1'b0);
        check("R1 pipelined first", {1'b0, q_valid, q_index}, 4'b0110);
        @(negedge clk);
        desc_valid = 1'b0;
        check("R1 gap", {3'b0, q_valid}, 4'd0);
        @(negedge clk);
        check("R1 pipelined second", {1'b0, q_valid, q_index}, 4'b0111);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule